// File: doc/BRIEF.md
# Serial Audio Link Input Frame Serializer

This block is the codec end of a time-slot serial audio link. It drives one serial data line, one bit per rising edge of the bit clock. A 256-bit frame is 16 tag bits followed by twelve 20-bit data slots. The controller marks each frame with a rising edge on a sync line. The block samples sync on falling bit-clock edges. When it sees sync go from low to high, it takes that falling edge as the frame start and places the first tag bit on the line at the next rising edge.

The tag phase carries a codec-ready flag, then one flag per data slot telling whether that slot holds valid data, then three reserved zeros. Each data slot is sent MSB first. A payload narrower than the slot is left-justified and padded with zeros. A slot whose flag is clear is sent as all zeros. The ready flag, the slot flags and every payload are captured in a single image on the rising edge that sends the first tag bit. The register side may therefore change them at any time during a frame without corrupting it. Once the 256 bits are out and no new frame has started, the line stays low.

Top module: `serin_frame_tx`

## Requirements
- R1: While `rst_n` is low, and after its release until the first sync rise is seen, `ser_out` is 0.
- R2: A frame starts only on a falling `bclk` edge where `sync` is sampled high after having been sampled low on the previous falling edge. Its bit 0 appears at the following rising edge. Holding `sync` high starts no further frame, and a new rise part-way through a frame abandons that frame and starts a new one.
- R3: Frame bit 0 equals `codec_ready`.
- R4: Frame bits 1 to 12 carry `slot_valid[0]` to `slot_valid[11]` in that order, where `slot_valid[k-1]` belongs to data slot k.
- R5: Frame bits 13, 14 and 15 are 0.
- R6: Data slot k (k = 1 to 12) occupies frame bits 16+20(k-1) to 35+20(k-1), sent MSB first. The payload `slot_data[(k-1)*PAYLOAD_W +: PAYLOAD_W]` fills the first PAYLOAD_W bits of the slot, and the remaining 20-PAYLOAD_W bits are 0.
- R7: Every bit of a data slot whose valid flag is 0 is sent as 0, whatever the payload.
- R8: The frame sent is built from the inputs as they stand at the rising edge that sends bit 0. Changes to those inputs after that edge do not alter the frame.
- R9: Exactly one frame bit is sent per rising edge, 256 bits per frame. After the last bit, `ser_out` stays 0 until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock. Data is launched on the rising edge and sync is sampled on the falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `bclk` |
| sync | input | 1 | Frame marker from the controller. A rising edge starts a frame. |
| codec_ready | input | 1 | Ready flag sent as frame bit 0 |
| slot_valid | input | NUM_SLOTS | Valid flag per data slot. Bit 0 belongs to slot 1. |
| slot_data | input | NUM_SLOTS*PAYLOAD_W | Payloads, with slot 1 in the lowest PAYLOAD_W bits |
| ser_out | output | 1 | Serial frame data, MSB first |

## Verification
Sync is driven one time unit after a rising edge. The falling edge that follows registers the start, and bit j of the frame appears after the (j+1)-th rising edge counted from the edge where sync was raised. The bench therefore compares bit j one unit after that edge, while the line is stable. Captured inputs are snapshotted at the moment sync is raised, because they are latched at the edge that sends bit 0. Mid-frame input changes are applied after that edge and must leave the expected stream untouched. Idle and restart checks use the same bit-to-edge offset, so a frame restarted after bit n yields the new bit 0 on the very next rising edge.

// File: rtl/serin_pkg.sv
package serin_pkg;
  // Reserved positions at the end of the tag phase, always sent as zero.
  localparam int unsigned TAG_RSV_W = 3;
  // Depth of the reset release synchronizer.
  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/serin_rst_sync.sv
module serin_rst_sync #(
  parameter int unsigned STAGES = serin_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_n_o = pipe_q[STAGES-1];
endmodule

// File: rtl/serin_sync_edge.sv
// Samples the frame marker on the falling bit-clock edge and flags a
// low-to-high change for exactly one bit period.
module serin_sync_edge (
  input  logic bclk,
  input  logic rst_n,
  input  logic sync_i,
  output logic start_o
);
  logic smp_q, smp_d;
  logic start_q, start_d;

  always_comb begin
    smp_d   = sync_i;
    start_d = sync_i & ~smp_q;
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      smp_q   <= smp_d;
      start_q <= start_d;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/serin_frame_pack.sv
// Assembles the full zero-stuffed frame image, first bit at the MSB.
module serin_frame_pack #(
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned PAYLOAD_W = 20,
  localparam int unsigned TAG_W    = 1 + NUM_SLOTS + serin_pkg::TAG_RSV_W,
  localparam int unsigned FRAME_W  = TAG_W + NUM_SLOTS * SLOT_W
) (
  input  logic                           ready_i,
  input  logic [NUM_SLOTS-1:0]           valid_i,
  input  logic [NUM_SLOTS*PAYLOAD_W-1:0] data_i,
  output logic [FRAME_W-1:0]             frame_o
);
  localparam int unsigned PAD_W = SLOT_W - PAYLOAD_W;

  logic [TAG_W-1:0] tag;

  assign tag[TAG_W-1] = ready_i;
  assign tag[serin_pkg::TAG_RSV_W-1:0] = '0;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_tag
    assign tag[TAG_W-2-i] = valid_i[i];
  end

  assign frame_o[FRAME_W-1 -: TAG_W] = tag;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam int unsigned HI = FRAME_W - 1 - TAG_W - i * SLOT_W;
    if (PAD_W == 0) begin : g_full
      assign frame_o[HI -: SLOT_W] =
        valid_i[i] ? data_i[i*PAYLOAD_W +: PAYLOAD_W] : '0;
    end else begin : g_pad
      assign frame_o[HI -: SLOT_W] =
        valid_i[i] ? {data_i[i*PAYLOAD_W +: PAYLOAD_W], {PAD_W{1'b0}}} : '0;
    end
  end
endmodule

// File: rtl/serin_frame_tx.sv
module serin_frame_tx #(
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned PAYLOAD_W = 20
) (
  input  logic                           bclk,
  input  logic                           rst_n,
  input  logic                           sync,
  input  logic                           codec_ready,
  input  logic [NUM_SLOTS-1:0]           slot_valid,
  input  logic [NUM_SLOTS*PAYLOAD_W-1:0] slot_data,
  output logic                           ser_out
);
  localparam int unsigned TAG_W   = 1 + NUM_SLOTS + serin_pkg::TAG_RSV_W;
  localparam int unsigned FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;

  logic               rst_sync_n;
  logic               frame_start;
  logic [FRAME_W-1:0] frame_img;

  serin_rst_sync u_rst (
    .clk     (bclk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  serin_sync_edge u_edge (
    .bclk    (bclk),
    .rst_n   (rst_sync_n),
    .sync_i  (sync),
    .start_o (frame_start)
  );

  serin_frame_pack #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .PAYLOAD_W (PAYLOAD_W)
  ) u_pack (
    .ready_i (codec_ready),
    .valid_i (slot_valid),
    .data_i  (slot_data),
    .frame_o (frame_img)
  );

  // Output bit plus the not-yet-sent remainder of the captured frame.
  logic               out_q, out_d;
  logic [FRAME_W-2:0] rest_q, rest_d;
  logic               shift_en;

  always_comb begin
    shift_en = frame_start | out_q | (|rest_q);
    if (frame_start) {out_d, rest_d} = frame_img;
    else             {out_d, rest_d} = {rest_q, 1'b0};
  end

  always_ff @(posedge bclk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q  <= 1'b0;
      rest_q <= '0;
    end else if (shift_en) begin
      out_q  <= out_d;
      rest_q <= rest_d;
    end
  end

  assign ser_out = out_q;
endmodule

// File: rtl/serin_frame_chk.sv
module serin_frame_chk #(
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned SLOT_W    = 20
) (
  input logic                 bclk,
  input logic                 rst_ok,
  input logic                 sync,
  input logic                 codec_ready,
  input logic [NUM_SLOTS-1:0] slot_valid,
  input logic                 ser_out
);
  localparam int unsigned TAG_W   = 1 + NUM_SLOTS + serin_pkg::TAG_RSV_W;
  localparam int unsigned FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int unsigned CW      = $clog2(FRAME_W + 1);
  localparam int unsigned SIW     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic                 sync_s, rise_seen;
  logic [CW-1:0]        pos;
  logic                 cap_ready;
  logic [NUM_SLOTS-1:0] cap_valid;

  always_ff @(negedge bclk or negedge rst_ok) begin
    if (!rst_ok) begin
      sync_s    <= 1'b0;
      rise_seen <= 1'b0;
    end else begin
      sync_s    <= sync;
      rise_seen <= sync & ~sync_s;
    end
  end

  always_ff @(posedge bclk or negedge rst_ok) begin
    if (!rst_ok) begin
      pos       <= CW'(FRAME_W);
      cap_ready <= 1'b0;
      cap_valid <= '0;
    end else if (rise_seen) begin
      pos       <= '0;
      cap_ready <= codec_ready;
      cap_valid <= slot_valid;
    end else if (pos != CW'(FRAME_W)) begin
      pos <= pos + CW'(1);
    end
  end

  int unsigned    pos_i;
  logic [SIW-1:0] tag_idx;
  logic [SIW-1:0] slot_idx;
  logic           in_tag_vld, in_rsv, in_slots;

  always_comb begin
    pos_i      = int'(pos);
    in_tag_vld = (pos_i >= 1) && (pos_i <= NUM_SLOTS);
    in_rsv     = (pos_i > NUM_SLOTS) && (pos_i < TAG_W);
    in_slots   = (pos_i >= TAG_W) && (pos_i < FRAME_W);
    tag_idx    = in_tag_vld ? SIW'(pos_i - 1) : '0;
    slot_idx   = in_slots ? SIW'((pos_i - TAG_W) / SLOT_W) : '0;
  end

  always @(negedge bclk) begin
    if (!rst_ok) assert_reset_quiet_R1: assert (ser_out == 1'b0);
  end

  assert_first_bit_ready_R3: assert property (@(posedge bclk) disable iff (!rst_ok)
    (pos == '0) |-> (ser_out == cap_ready));

  assert_tag_flags_R4: assert property (@(posedge bclk) disable iff (!rst_ok)
    in_tag_vld |-> (ser_out == cap_valid[tag_idx]));

  assert_reserved_zero_R5: assert property (@(posedge bclk) disable iff (!rst_ok)
    in_rsv |-> (ser_out == 1'b0));

  assert_empty_slot_R7: assert property (@(posedge bclk) disable iff (!rst_ok)
    (in_slots && !cap_valid[slot_idx]) |-> (ser_out == 1'b0));

  assert_line_idle_R9: assert property (@(posedge bclk) disable iff (!rst_ok)
    (pos == CW'(FRAME_W)) |-> (ser_out == 1'b0));
endmodule

bind serin_frame_tx serin_frame_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .SLOT_W    (SLOT_W)
) u_chk (
  .bclk        (bclk),
  .rst_ok      (rst_sync_n),
  .sync        (sync),
  .codec_ready (codec_ready),
  .slot_valid  (slot_valid),
  .ser_out     (ser_out)
);

// File: tb/test_serin_frame_tx.sv
module test_serin_frame_tx;
  // Period of 4 time units stands for the 250 MHz bench clock.
  localparam int NS = 12;
  localparam int SW = 20;
  localparam int PW = 18;
  localparam int FW = 16 + NS * SW;

  logic             bclk = 1'b0;
  logic             rst_n;
  logic             sync;
  logic             codec_ready;
  logic [NS-1:0]    slot_valid;
  logic [NS*PW-1:0] slot_data;
  logic             ser_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic             e_rdy;
  logic [NS-1:0]    e_vld;
  logic [NS*PW-1:0] e_dat;

  always #2 bclk = ~bclk;

  serin_frame_tx #(.NUM_SLOTS(NS), .SLOT_W(SW), .PAYLOAD_W(PW)) i_serin_frame_tx (
    .bclk(bclk), .rst_n(rst_n), .sync(sync), .codec_ready(codec_ready),
    .slot_valid(slot_valid), .slot_data(slot_data), .ser_out(ser_out)
  );

  task automatic check(input logic got, input logic exp, input string req, input int j);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s bit %0d: got %b expected %b", req, j, got, exp);
    end
  endtask

  function automatic logic exp_bit(input int j);
    int s, b;
    if (j == 0) return e_rdy;
    if (j <= NS) return e_vld[j-1];
    if (j < 16) return 1'b0;
    s = (j - 16) / SW;
    b = (j - 16) % SW;
    if (!e_vld[s] || b >= PW) return 1'b0;
    return e_dat[s*PW + PW - 1 - b];
  endfunction

  function automatic string req_of(input int j);
    if (j == 0) return "R3";
    if (j <= NS) return "R4";
    if (j < 16) return "R5";
    if (e_vld[(j-16)/SW]) return "R6";
    return "R7";
  endfunction

  task automatic randomize_inputs();
    codec_ready = 1'($urandom);
    slot_valid  = NS'($urandom);
    for (int k = 0; k < NS; k++) slot_data[k*PW +: PW] = PW'($urandom);
  endtask

  // Raise sync; check each bit. change_mid rewrites inputs after bit 3,
  // hold keeps sync high, cut restarts the frame after bit cut.
  task automatic send_frame(input bit change_mid, input bit hold, input int cut);
    int  j = 0;
    int  c = cut;
    bit  restarted = 0;
    @(posedge bclk); #1;
    sync = 1'b1;
    e_rdy = codec_ready; e_vld = slot_valid; e_dat = slot_data;
    while (j < FW) begin
      @(posedge bclk); #1;
      if (restarted && j == 0) check(ser_out, exp_bit(0), "R2", 0);
      else if (change_mid && j > 3 && j >= 16) check(ser_out, exp_bit(j), "R8", j);
      else check(ser_out, exp_bit(j), req_of(j), j);
      if (change_mid && j == 3) randomize_inputs();
      if (j == 15 && !hold) sync = 1'b0;
      if (j == c) begin
        randomize_inputs();
        sync = 1'b1;
        e_rdy = codec_ready; e_vld = slot_valid; e_dat = slot_data;
        c = -1; restarted = 1; j = 0;
      end else begin
        j++;
      end
    end
  endtask

  task automatic idle_check(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge bclk); #1;
      check(ser_out, 1'b0, req, -1);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync = 1'b0;
    codec_ready = 1'b1; slot_valid = '1; slot_data = '1;
    // R1: quiet during and after reset without a sync rise
    idle_check(6, "R1");
    rst_n = 1'b1;
    idle_check(8, "R1");

    // R6: all slots valid, all-ones payload exposes the padding
    send_frame(0, 0, FW);
    idle_check(4, "R9");

    // R7: nothing valid, payload non-zero
    codec_ready = 1'b1; slot_valid = '0; slot_data = '1;
    send_frame(0, 0, FW);

    // R4/R6/R7: one valid slot at a time
    for (int k = 0; k < NS; k++) begin
      codec_ready = 1'(k); slot_valid = NS'(1) << k;
      for (int m = 0; m < NS; m++) slot_data[m*PW +: PW] = PW'($urandom);
      send_frame(0, 0, FW);
    end

    // R3/R4: ready low, alternating flags
    codec_ready = 1'b0; slot_valid = NS'(12'hA5A);
    send_frame(0, 0, FW);

    // random patterns
    for (int r = 0; r < 6; r++) begin
      randomize_inputs();
      send_frame(0, 0, FW);
    end

    // R8: inputs rewritten during the frame
    for (int r = 0; r < 3; r++) begin
      randomize_inputs(); slot_valid = '1;
      send_frame(1, 0, FW);
    end

    // R2: sync held high gives no second frame
    randomize_inputs();
    send_frame(0, 1, FW);
    idle_check(20, "R2");
    sync = 1'b0;
    idle_check(3, "R9");

    // R2: restart part-way through a frame
    randomize_inputs();
    send_frame(0, 0, 100);
    idle_check(10, "R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule